// File: doc/BRIEF.md
# Per-Channel Output Override on Run-State Change

This block sits between user logic and a bank of output channels. For every channel it decides, cycle by cycle, what reaches the channel. The choice depends on the run state of a simulation that a host controls. In the execute state, every channel carries its user-logic sample. In the pause and reset states, each channel follows its own policy. There is one policy for pause and a separate one for reset.

A policy does one of three things:

- drives a programmed constant;
- passes the user sample through;
- freezes the value the channel was driving when the state began.

The host's run state arrives as a 2-bit code. Both policies and the constant for each channel are plain configuration inputs. The constant may be rewritten at any time. The driven values leave the block through a register, one cycle after the inputs that select them.

A small state machine records the run state seen on the previous cycle. It has three states, EXEC, PAUSE and RESET, and it comes out of the block's own reset in RESET. Any clock on which the decoded state differs from the recorded one is an *entry*. The named entries are:

- EXEC→PAUSE, EXEC→RESET, PAUSE→RESET, RESET→PAUSE: an entry into a state with a policy.
- PAUSE→EXEC, RESET→EXEC: the return to execute.

On an entry, every channel loads its hold register from its present output.

Top module: `chan_output_guard`

## Requirements
- R1: When the run code is 00 (execute), each channel's output equals that channel's user sample from one clock earlier, whatever its policies.
- R2: Run code 01 means pause, and 10 means reset. Code 11 is treated as reset, so a move between codes 10 and 11 is not an entry.
- R3: In pause a channel obeys only its pause policy, and in reset only its reset policy. The two policies are independent.
- R4: Policy code 01 (constant) drives the channel's assigned value, registered one cycle, whatever the user sample is.
- R5: Policy code 00 (pass-through) forwards the user sample as in execute. Code 11 behaves the same as 00.
- R6: Policy code 10 (keep) holds the output that was present on the entry clock. The hold lasts for as long as the state lasts, including while the user sample and the assigned value change.
- R7: On return to execute, the output takes the live user sample from the entry clock onward. A step in the output is allowed.
- R8: A direct change from pause to reset is an entry. Under a reset keep policy, the channel holds whatever it was driving at that moment.
- R9: Rewriting a channel's assigned value has no effect on its output unless the active policy is constant.
- R10: While the block reset is high, every output is 0, the recorded state becomes RESET and each hold register is cleared. As a result, a reset keep policy after the block reset drives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset, active high |
| run_code | input | 2 | Host run state: 00 execute, 01 pause, 10/11 reset |
| pause_policy | input | 2*N | Pause policy per channel, channel c at bits [2c+1:2c] |
| reset_policy | input | 2*N | Reset policy per channel, channel c at bits [2c+1:2c] |
| assigned_val | input | N*W | Programmed constant per channel, channel c at bits [cW+W-1:cW] |
| user_val | input | N*W | User-logic sample per channel, same packing |
| drive_val | output | N*W | Registered driven value per channel, same packing |

## Verification
The stimulus includes directed walks through the following:

- execute, then pause, then a direct pause-to-reset change, then code 11, then execute again. Each channel carries a different policy for pause and for reset, so swapped or shared policies show up as wrong values.
- keep-mode intervals while the user sample changes every clock. These separate a true freeze from a pass-through, and a capture on the entry clock from a capture one cycle late.
- changes to the assigned value under pass and keep policies. These expose leaks of the constant.
- the interval right after the block reset. This shows whether hold registers start at zero.

A long, seeded random run follows. In it, run codes change, policies change and block resets arrive without notice. This stresses entries that occur back to back and entries that occur mid-policy.

// File: rtl/chan_guard_pkg.sv
package chan_guard_pkg;

    typedef enum logic [1:0] {
        RUN_EXEC  = 2'b00,
        RUN_PAUSE = 2'b01,
        RUN_RESET = 2'b10
    } run_e;

    typedef enum logic [1:0] {
        MODE_PASS  = 2'b00,
        MODE_CONST = 2'b01,
        MODE_KEEP  = 2'b10
    } mode_e;

    // Host run code to effective state; anything not execute or pause is reset.
    function automatic run_e decode_run(input logic [1:0] code);
        run_e r;
        unique case (code)
            2'b00:   r = RUN_EXEC;
            2'b01:   r = RUN_PAUSE;
            default: r = RUN_RESET;
        endcase
        return r;
    endfunction

    // Policy code to behaviour; the unused code falls back to pass-through.
    function automatic mode_e decode_mode(input logic [1:0] code);
        mode_e m;
        unique case (code)
            2'b01:   m = MODE_CONST;
            2'b10:   m = MODE_KEEP;
            default: m = MODE_PASS;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/run_phase_fsm.sv
module run_phase_fsm
    import chan_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] run_code,
    output run_e       phase,
    output logic       entry
);

    run_e prev_q;

    // State register: the effective state seen on the previous clock.
    always_ff @(posedge clk) begin
        if (rst) prev_q <= RUN_RESET;
        else     prev_q <= phase;
    end

    // Outputs: the present state and the entry strobe.
    always_comb begin
        phase = decode_run(run_code);
        unique case (prev_q)
            RUN_EXEC:  entry = (phase != RUN_EXEC);
            RUN_PAUSE: entry = (phase != RUN_PAUSE);
            RUN_RESET: entry = (phase != RUN_RESET);
            default:   entry = 1'b1;
        endcase
    end

    // R10: after the block reset the recorded state is RESET.
    assert_reset_state_R10: assert property (@(posedge clk)
        rst |=> (entry == (decode_run(run_code) != RUN_RESET)));

    // R2: codes 10 and 11 are the same state, so moving between them is no entry.
    assert_code_alias_R2: assert property (@(posedge clk) disable iff (rst)
        (run_code[1] && $past(run_code[1]) && !$past(rst)) |-> !entry);

endmodule

// File: rtl/chan_lane.sv
module chan_lane
    import chan_guard_pkg::*;
#(
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  run_e                phase,
    input  logic                entry,
    input  logic [1:0]          pause_sel,
    input  logic [1:0]          reset_sel,
    input  logic signed [W-1:0] assigned,
    input  logic signed [W-1:0] user,
    output logic signed [W-1:0] dout
);

    mode_e               act;
    logic signed [W-1:0] out_q;
    logic signed [W-1:0] hold_q;
    logic signed [W-1:0] out_d;
    logic signed [W-1:0] hold_d;

    // Active policy for the present state.
    always_comb begin
        unique case (phase)
            RUN_PAUSE: act = decode_mode(pause_sel);
            RUN_RESET: act = decode_mode(reset_sel);
            default:   act = MODE_PASS;
        endcase
    end

    // Next output and next hold value.
    always_comb begin
        hold_d = entry ? out_q : hold_q;
        unique case (act)
            MODE_CONST: out_d = assigned;
            MODE_KEEP:  out_d = entry ? out_q : hold_q;
            default:    out_d = user;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q  <= '0;
            hold_q <= '0;
        end else begin
            out_q  <= out_d;
            hold_q <= hold_d;
        end
    end

    assign dout = out_q;

    assert_exec_pass_R1: assert property (@(posedge clk) disable iff (rst)
        (phase == RUN_EXEC) |=> (dout == $past(user)));

    assert_const_drive_R4: assert property (@(posedge clk) disable iff (rst)
        (phase != RUN_EXEC && act == MODE_CONST) |=> (dout == $past(assigned)));

    assert_policy_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (phase != RUN_EXEC && act == MODE_PASS) |=> (dout == $past(user)));

    assert_keep_entry_R6: assert property (@(posedge clk) disable iff (rst)
        (act == MODE_KEEP && entry) |=> $stable(dout));

    assert_keep_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (act == MODE_KEEP && !entry) |=> (dout == $past(hold_q)));

endmodule

// File: rtl/chan_output_guard.sv
module chan_output_guard
    import chan_guard_pkg::*;
#(
    parameter int N = 8,
    parameter int W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       run_code,
    input  logic [2*N-1:0]   pause_policy,
    input  logic [2*N-1:0]   reset_policy,
    input  logic [N*W-1:0]   assigned_val,
    input  logic [N*W-1:0]   user_val,
    output logic [N*W-1:0]   drive_val
);

    localparam int DBUS = N * W;

    run_e phase;
    logic entry;

    run_phase_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .run_code (run_code),
        .phase    (phase),
        .entry    (entry)
    );

    for (genvar c = 0; c < N; c++) begin : g_lane
        logic signed [W-1:0] lane_out;

        chan_lane #(.W(W)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .phase     (phase),
            .entry     (entry),
            .pause_sel (pause_policy[2*c +: 2]),
            .reset_sel (reset_policy[2*c +: 2]),
            .assigned  (assigned_val[c*W +: W]),
            .user      (user_val[c*W +: W]),
            .dout      (lane_out)
        );

        assign drive_val[c*W +: W] = lane_out;
    end

    // R10: the block reset clears every output.
    assert_reset_out_R10: assert property (@(posedge clk)
        rst |=> (drive_val == {DBUS{1'b0}}));

endmodule

// File: tb/chan_output_guard_tb.sv
module chan_output_guard_tb_top;

    localparam int N = 8;
    localparam int W = 16;

    logic             clk = 1'b0;
    logic             rst;
    logic [1:0]       run_code;
    logic [2*N-1:0]   pause_policy;
    logic [2*N-1:0]   reset_policy;
    logic [N*W-1:0]   assigned_val;
    logic [N*W-1:0]   user_val;
    logic [N*W-1:0]   drive_val;

    always #5 clk = ~clk;

    chan_output_guard #(.N(N), .W(W)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .run_code     (run_code),
        .pause_policy (pause_policy),
        .reset_policy (reset_policy),
        .assigned_val (assigned_val),
        .user_val     (user_val),
        .drive_val    (drive_val)
    );

    int        n_checks = 0;
    int        n_fail   = 0;
    bit        done     = 0;
    logic [W-1:0] e_out  [N];
    logic [W-1:0] e_hold [N];
    logic [1:0]   e_prev;
    string        e_tag  [N];
    string        extra = "";

    // Effective state: 0 execute, 1 pause, 2 reset (R2).
    function automatic logic [1:0] state_of(input logic [1:0] c);
        if (c == 2'b00) return 2'd0;
        if (c == 2'b01) return 2'd1;
        return 2'd2;
    endfunction

    // Model the clock edge that follows the inputs now applied.
    task automatic model_update();
        logic [1:0] st;
        logic       ent;
        if (rst) begin
            for (int c = 0; c < N; c++) begin
                e_out[c]  = '0;
                e_hold[c] = '0;
                e_tag[c]  = "R10";
            end
            e_prev = 2'd2;
        end else begin
            st  = state_of(run_code);
            ent = (st != e_prev);
            for (int c = 0; c < N; c++) begin
                logic [1:0] m;
                logic [W-1:0] nx;
                string t;
                m = (st == 2'd1) ? pause_policy[2*c +: 2] :
                    (st == 2'd2) ? reset_policy[2*c +: 2] : 2'b00;
                if (m == 2'b01) begin
                    nx = assigned_val[c*W +: W];
                    t  = "R3 R4";
                end else if (m == 2'b10) begin
                    nx = ent ? e_out[c] : e_hold[c];
                    t  = (ent && e_prev == 2'd1 && st == 2'd2) ? "R3 R8" : "R3 R6";
                end else begin
                    nx = user_val[c*W +: W];
                    if (st == 2'd0) t = (ent) ? "R7" : "R1";
                    else            t = "R3 R5";
                end
                if (run_code == 2'b11) t = {t, " R2"};
                if (ent) e_hold[c] = e_out[c];
                e_out[c] = nx;
                e_tag[c] = {t, " ", extra};
            end
            e_prev = st;
        end
    endtask

    task automatic check_all();
        for (int c = 0; c < N; c++) begin
            n_checks++;
            if (drive_val[c*W +: W] !== e_out[c]) begin
                n_fail++;
                $display("FAIL %s ch%0d actual %h expected %h", e_tag[c], c,
                         drive_val[c*W +: W], e_out[c]);
            end
        end
    endtask

    task automatic tick();
        model_update();
        @(negedge clk);
        check_all();
    endtask

    task automatic rand_user();
        for (int c = 0; c < N; c++) user_val[c*W +: W] = W'($urandom);
    endtask

    task automatic rand_assigned();
        for (int c = 0; c < N; c++) assigned_val[c*W +: W] = W'($urandom);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1;
        run_code = 2'b00;
        pause_policy = '0;
        reset_policy = {N{2'b10}};
        rand_assigned();
        rand_user();
        @(negedge clk);

        // R10: outputs cleared under block reset.
        extra = "R10";
        repeat (2) begin rand_user(); tick(); end
        // R10: reset keep policy after block reset drives zero.
        rst = 1'b0;
        run_code = 2'b10;
        repeat (3) begin rand_user(); tick(); end

        // R1: execute passes everything through.
        extra = "R1";
        run_code = 2'b00;
        repeat (4) begin rand_user(); rand_assigned(); tick(); end

        // R3/R9 policies: pause and reset differ per channel.
        pause_policy = {2'b10, 2'b01, 2'b00, 2'b11, 2'b10, 2'b01, 2'b00, 2'b10};
        reset_policy = {2'b00, 2'b10, 2'b01, 2'b10, 2'b01, 2'b10, 2'b10, 2'b11};
        extra = "R9";
        run_code = 2'b01;
        repeat (5) begin rand_user(); rand_assigned(); tick(); end

        // R8: direct pause to reset recaptures.
        extra = "R8";
        run_code = 2'b10;
        repeat (4) begin rand_user(); rand_assigned(); tick(); end

        // R2: code 11 is still reset, no recapture.
        extra = "R2";
        run_code = 2'b11;
        repeat (4) begin rand_user(); rand_assigned(); tick(); end

        // R7: back to execute resumes live data.
        extra = "R7";
        run_code = 2'b00;
        repeat (3) begin rand_user(); tick(); end

        // Random phase.
        extra = "rand";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(7) == 0) run_code = 2'($urandom);
            for (int c = 0; c < N; c++) begin
                if ($urandom_range(31) == 0) pause_policy[2*c +: 2] = 2'($urandom);
                if ($urandom_range(31) == 0) reset_policy[2*c +: 2] = 2'($urandom);
            end
            if ($urandom_range(3) == 0) rand_assigned();
            rand_user();
            rst = ($urandom_range(499) == 0);
            tick();
        end
        rst = 1'b0;
        finish_run();
    end

endmodule